// File: doc/BRIEF.md
# Temporal Guard Unit Array

This block holds a pool of independent temporal guards for a deterministic control core. Each guard is set up by a command as either a shift-history guard, which becomes active once its condition has been high for N ticks in a row, or as a countdown guard, which becomes active once a target number of high ticks has been counted since the last reload. Guards only advance when told to by a per-guard tick command. A per-guard condition latch holds the bit the guard samples on each tick. The core rewrites it between ticks, the way a bound condition register would be.

A query port reads one guard, or combines two guards with AND or OR, and returns a registered result. An optional deadline counter per guard counts that guard's ticks and raises a deadline-miss exception (code 4) if the guard does not fire before the count runs out. Ticks are ignored while the core is in host mode. Indices that point past the populated pool are reported as out of range rather than touching any guard.

Top module: `tguard_array`

## Requirements
- R1: After reset every guard is a shift-history guard of length 1 with an empty history, a low condition latch and no deadline. Every query returns inactive, and `cmd_oob`, `res_valid` and `exc_valid` are low.
- R2: Command op 0 (init shift-history) sets the length to `cmd_arg[LEN_W-1:0] + 1` and clears the history. The guard is active exactly when the last `length` ticks all sampled a high condition latch, so any low tick makes it inactive.
- R3: Command op 1 (init countdown) loads the target `cmd_arg[CNT_W-1:0]` into the count. A tick with a high latch decrements the count, saturating at zero. A tick with a low latch reloads the target. The guard is active while the count is zero, so a target of 0 is active at once.
- R4: Both init ops load the condition latch from `cmd_cond`, op 2 (set condition) replaces it, and op 3 (tick) samples it. Changing the latch alone does not change the active state.
- R5: A query with `q_op` 0 or 3 returns guard A, 1 returns A AND B, and 2 returns A OR B. The result appears with `res_valid` one cycle after `q_valid` and reflects the state before any command taking effect at the same edge.
- R6: While `host_mode` is high a tick command changes neither the guard nor its deadline counter. Other commands still take effect.
- R7: Command op 4 with a nonzero `cmd_arg[DL_W-1:0]` = D arms the deadline. If D ticks pass without the guard being active after any of them, `exc_valid` pulses for one cycle after the D-th tick, with `exc_code` 4 and `exc_guard` set to that guard's index.
- R8: A tick after which the guard is active disarms its deadline, including on the D-th tick itself. Op 4 with D = 0 disarms.
- R9: Re-initializing a guard with op 0 or op 1 clears its history or count state and disarms its deadline.
- R10: A command whose index is not below GUARD_CNT raises `cmd_oob` for one cycle and changes no guard. A query whose guard A index, or guard B index under AND or OR, is out of range returns `res_oob` high and `res_active` low.
- R11: Command ops 5, 6 and 7 have no effect on any guard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_mode | input | 1 | High while the core is in host mode, suspending ticks |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode (0 init shift, 1 init count, 2 set condition, 3 tick, 4 set deadline) |
| cmd_idx | input | IDX_W | Target guard index |
| cmd_arg | input | ARG_W | Length, target or deadline argument |
| cmd_cond | input | 1 | Condition bit for init and set-condition |
| q_valid | input | 1 | Query strobe |
| q_op | input | 2 | Query combine select |
| q_idx_a | input | IDX_W | First queried guard |
| q_idx_b | input | IDX_W | Second queried guard |
| res_valid | output | 1 | Query result valid |
| res_active | output | 1 | Query result |
| res_oob | output | 1 | Query index out of range |
| cmd_oob | output | 1 | Command index out of range |
| exc_valid | output | 1 | Exception pulse |
| exc_code | output | 4 | Exception code (4 = deadline miss, 0 otherwise) |
| exc_guard | output | IDX_W | Guard that missed its deadline |

## Verification
Every result of this block is registered once. A query result, a `cmd_oob` flag and a deadline-miss pulse are all due in the cycle after the clock edge that accepted the command or query. The bench drives each stimulus on a falling edge, lets one rising edge pass and samples on the next falling edge, where that one cycle's result is settled. The bench model applies a command only after it has captured the expected value of any query issued in the same cycle, which reproduces the read-before-update ordering. Shift lengths 1 to 8 and targets 0 to 15 are swept on a six-guard pool, along with every query pair and combine op.

// File: rtl/tguard_pkg.sv
package tguard_pkg;

   localparam logic [2:0] OP_INIT_SR  = 3'd0;
   localparam logic [2:0] OP_INIT_CTR = 3'd1;
   localparam logic [2:0] OP_SET_COND = 3'd2;
   localparam logic [2:0] OP_TICK     = 3'd3;
   localparam logic [2:0] OP_SET_DL   = 3'd4;

   localparam logic [1:0] QOP_SINGLE  = 2'd0;
   localparam logic [1:0] QOP_AND     = 2'd1;
   localparam logic [1:0] QOP_OR      = 2'd2;

   localparam logic [3:0] EXC_NONE          = 4'd0;
   localparam logic [3:0] EXC_DEADLINE_MISS = 4'd4;

   typedef enum logic {
      KIND_SR  = 1'b0,
      KIND_CTR = 1'b1
   } tg_kind_e;

endpackage

// File: rtl/tguard_cell.sv
module tguard_cell
   import tguard_pkg::*;
#(
   parameter int SR_MAX_LEN = 32,
   parameter int CNT_W      = 8,
   localparam int LEN_W     = $clog2(SR_MAX_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_sr,
   input  logic             init_ctr,
   input  logic             set_cond,
   input  logic             tick,
   input  logic [LEN_W-1:0] arg_len,
   input  logic [CNT_W-1:0] arg_cnt,
   input  logic             cond_in,
   output logic             active,
   output logic             active_next
);

   if ((SR_MAX_LEN < 2) || ((SR_MAX_LEN & (SR_MAX_LEN - 1)) != 0)) begin : g_bad_len
      $error("tguard_cell: SR_MAX_LEN must be a power of two, at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("tguard_cell: CNT_W must be at least 1");
   end

   tg_kind_e              kind_q;
   logic [LEN_W-1:0]      len_q;
   logic [SR_MAX_LEN-1:0] hist_q;
   logic [CNT_W-1:0]      tgt_q;
   logic [CNT_W-1:0]      cnt_q;
   logic                  cond_q;

   logic [SR_MAX_LEN-1:0] len_mask;
   logic [SR_MAX_LEN-1:0] hist_step;
   logic [CNT_W-1:0]      cnt_step;

   always_comb begin
      for (int i = 0; i < SR_MAX_LEN; i++) begin
         len_mask[i] = (i <= int'(len_q));
      end
   end

   assign hist_step = {hist_q[SR_MAX_LEN-2:0], cond_q};

   always_comb begin
      if (!cond_q) begin
         cnt_step = tgt_q;
      end else if (cnt_q == '0) begin
         cnt_step = '0;
      end else begin
         cnt_step = cnt_q - CNT_W'(1);
      end
   end

   assign active      = (kind_q == KIND_SR) ? (&(hist_q | ~len_mask))
                                            : (cnt_q == '0);
   assign active_next = (kind_q == KIND_SR) ? (&(hist_step | ~len_mask))
                                            : (cnt_step == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= KIND_SR;
         len_q  <= '0;
         hist_q <= '0;
         tgt_q  <= '0;
         cnt_q  <= '0;
         cond_q <= 1'b0;
      end else if (init_sr) begin
         kind_q <= KIND_SR;
         len_q  <= arg_len;
         hist_q <= '0;
         tgt_q  <= '0;
         cnt_q  <= '0;
         cond_q <= cond_in;
      end else if (init_ctr) begin
         kind_q <= KIND_CTR;
         hist_q <= '0;
         tgt_q  <= arg_cnt;
         cnt_q  <= arg_cnt;
         cond_q <= cond_in;
      end else if (set_cond) begin
         cond_q <= cond_in;
      end else if (tick) begin
         if (kind_q == KIND_SR) begin
            hist_q <= hist_step;
         end else begin
            cnt_q  <= cnt_step;
         end
      end
   end

   AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({init_sr, init_ctr, set_cond, tick})); // R4
   AST_SR_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      tick && (kind_q == KIND_SR) && !cond_q |=> !active); // R2
   AST_CTR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      tick && (kind_q == KIND_CTR) && cond_q && (cnt_q == '0) |=> active); // R3
   AST_CTR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      tick && (kind_q == KIND_CTR) && !cond_q |=> cnt_q == $past(tgt_q)); // R3
   AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      init_sr |=> !active); // R9
   AST_COND_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      set_cond |=> active == $past(active)); // R4

endmodule

// File: rtl/tguard_deadline.sv
module tguard_deadline #(
   parameter int DL_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            arm,
   input  logic [DL_W-1:0] arg_dl,
   input  logic            tick,
   input  logic            fire,
   output logic            miss
);

   if (DL_W < 1) begin : g_bad_dl
      $error("tguard_deadline: DL_W must be at least 1");
   end

   logic            armed_q;
   logic [DL_W-1:0] cnt_q;

   assign miss = tick && armed_q && !fire && (cnt_q == DL_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (clear) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (arm) begin
         armed_q <= (arg_dl != '0);
         cnt_q   <= arg_dl;
      end else if (tick && armed_q) begin
         if (fire || (cnt_q == DL_W'(1))) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
         end else begin
            cnt_q   <= cnt_q - DL_W'(1);
         end
      end
   end

   AST_DL_DISARM_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
      tick && fire |=> !armed_q); // R8
   AST_DL_MISS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      miss |=> !miss && !armed_q); // R7
   AST_DL_ARMED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> cnt_q != '0); // R7
   AST_DL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !armed_q); // R9

endmodule

// File: rtl/tguard_query.sv
module tguard_query
   import tguard_pkg::*;
#(
   parameter int GUARD_CNT = 64,
   parameter int IDX_W     = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [GUARD_CNT-1:0] act_vec,
   input  logic                 q_valid,
   input  logic [1:0]           q_op,
   input  logic [IDX_W-1:0]     q_idx_a,
   input  logic [IDX_W-1:0]     q_idx_b,
   output logic                 res_valid,
   output logic                 res_active,
   output logic                 res_oob
);

   localparam int IDX_CAP = 1 << IDX_W;

   logic [IDX_CAP-1:0] act_pad;
   logic               a_ok, b_ok, uses_b, bit_a, bit_b, oob, val;

   assign act_pad = IDX_CAP'(act_vec);
   assign a_ok    = int'(q_idx_a) < GUARD_CNT;
   assign b_ok    = int'(q_idx_b) < GUARD_CNT;
   assign uses_b  = (q_op == QOP_AND) || (q_op == QOP_OR);
   assign bit_a   = a_ok && act_pad[q_idx_a];
   assign bit_b   = b_ok && act_pad[q_idx_b];
   assign oob     = !a_ok || (uses_b && !b_ok);

   always_comb begin
      unique case (q_op)
         QOP_AND: val = bit_a & bit_b;
         QOP_OR:  val = bit_a | bit_b;
         default: val = bit_a;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_active <= 1'b0;
         res_oob    <= 1'b0;
      end else begin
         res_valid  <= q_valid;
         res_active <= q_valid && !oob && val;
         res_oob    <= q_valid && oob;
      end
   end

   AST_RES_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |=> res_valid); // R5
   AST_OOB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      res_oob |-> !res_active && res_valid); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !q_valid |=> !res_valid && !res_active && !res_oob); // R5

endmodule

// File: rtl/tguard_array.sv
module tguard_array
   import tguard_pkg::*;
#(
   parameter int GUARD_CNT    = 64,
   parameter int IDX_W        = 6,
   parameter int SR_MAX_LEN   = 32,
   parameter int CNT_W        = 8,
   parameter int DL_W         = 16,
   parameter int ARG_W        = 16,
   parameter bit HAS_DEADLINE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_mode,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_op,
   input  logic [IDX_W-1:0] cmd_idx,
   input  logic [ARG_W-1:0] cmd_arg,
   input  logic             cmd_cond,
   input  logic             q_valid,
   input  logic [1:0]       q_op,
   input  logic [IDX_W-1:0] q_idx_a,
   input  logic [IDX_W-1:0] q_idx_b,
   output logic             res_valid,
   output logic             res_active,
   output logic             res_oob,
   output logic             cmd_oob,
   output logic             exc_valid,
   output logic [3:0]       exc_code,
   output logic [IDX_W-1:0] exc_guard
);

   localparam int IDX_CAP = 1 << IDX_W;
   localparam int LEN_W   = $clog2(SR_MAX_LEN);

   if ((GUARD_CNT < 1) || (GUARD_CNT > IDX_CAP)) begin : g_bad_pool
      $error("tguard_array: GUARD_CNT must fit the index width");
   end
   if ((ARG_W < LEN_W) || (ARG_W < CNT_W) || (ARG_W < DL_W)) begin : g_bad_arg
      $error("tguard_array: ARG_W too narrow for its fields");
   end

   logic                 cmd_in_range;
   logic                 cmd_ok;
   logic [GUARD_CNT-1:0] act_vec;
   logic [GUARD_CNT-1:0] act_nxt;
   logic [GUARD_CNT-1:0] miss_vec;
   logic                 exc_valid_q;
   logic [IDX_W-1:0]     exc_guard_q;
   logic                 cmd_oob_q;

   assign cmd_in_range = int'(cmd_idx) < GUARD_CNT;
   assign cmd_ok       = cmd_valid && cmd_in_range;

   for (genvar g = 0; g < GUARD_CNT; g++) begin : g_guard
      logic hit, do_init_sr, do_init_ctr, do_cond, do_tick, do_dl;

      assign hit         = cmd_ok && (cmd_idx == IDX_W'(g));
      assign do_init_sr  = hit && (cmd_op == OP_INIT_SR);
      assign do_init_ctr = hit && (cmd_op == OP_INIT_CTR);
      assign do_cond     = hit && (cmd_op == OP_SET_COND);
      assign do_tick     = hit && (cmd_op == OP_TICK) && !host_mode;
      assign do_dl       = hit && (cmd_op == OP_SET_DL);

      tguard_cell #(
         .SR_MAX_LEN (SR_MAX_LEN),
         .CNT_W      (CNT_W)
      ) u_cell (
         .clk         (clk),
         .rst_n       (rst_n),
         .init_sr     (do_init_sr),
         .init_ctr    (do_init_ctr),
         .set_cond    (do_cond),
         .tick        (do_tick),
         .arg_len     (cmd_arg[LEN_W-1:0]),
         .arg_cnt     (cmd_arg[CNT_W-1:0]),
         .cond_in     (cmd_cond),
         .active      (act_vec[g]),
         .active_next (act_nxt[g])
      );

      if (HAS_DEADLINE) begin : g_dl
         tguard_deadline #(
            .DL_W (DL_W)
         ) u_dl (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (do_init_sr || do_init_ctr),
            .arm    (do_dl),
            .arg_dl (cmd_arg[DL_W-1:0]),
            .tick   (do_tick),
            .fire   (act_nxt[g]),
            .miss   (miss_vec[g])
         );
      end else begin : g_no_dl
         assign miss_vec[g] = 1'b0;
      end
   end

   tguard_query #(
      .GUARD_CNT (GUARD_CNT),
      .IDX_W     (IDX_W)
   ) u_query (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_vec    (act_vec),
      .q_valid    (q_valid),
      .q_op       (q_op),
      .q_idx_a    (q_idx_a),
      .q_idx_b    (q_idx_b),
      .res_valid  (res_valid),
      .res_active (res_active),
      .res_oob    (res_oob)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exc_valid_q <= 1'b0;
         exc_guard_q <= '0;
         cmd_oob_q   <= 1'b0;
      end else begin
         exc_valid_q <= |miss_vec;
         exc_guard_q <= (|miss_vec) ? cmd_idx : '0;
         cmd_oob_q   <= cmd_valid && !cmd_in_range;
      end
   end

   assign exc_valid = exc_valid_q;
   assign exc_code  = exc_valid_q ? EXC_DEADLINE_MISS : EXC_NONE;
   assign exc_guard = exc_guard_q;
   assign cmd_oob   = cmd_oob_q;

   AST_MISS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(miss_vec)); // R7
   AST_EXC_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> $past(cmd_valid && (cmd_op == OP_TICK))); // R7
   AST_HOST_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && host_mode |=> !exc_valid); // R6
   AST_OOB_NO_EXC: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_in_range |=> cmd_oob && !exc_valid); // R10
   AST_HOST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && host_mode && (cmd_op == OP_TICK) |=> act_vec == $past(act_vec)); // R6

endmodule

// File: tb/tguard_array_bench.sv
module tguard_array_bench;

   localparam int CLK_PERIOD = 10;
   localparam int GC  = 6;
   localparam int IW  = 3;
   localparam int SRL = 8;
   localparam int CW  = 4;
   localparam int DW  = 6;
   localparam int AW  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_mode = 1'b0;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = '0;
   logic [IW-1:0] cmd_idx = '0;
   logic [AW-1:0] cmd_arg = '0;
   logic          cmd_cond = 1'b0;
   logic          q_valid = 1'b0;
   logic [1:0]    q_op = '0;
   logic [IW-1:0] q_idx_a = '0;
   logic [IW-1:0] q_idx_b = '0;
   logic          res_valid, res_active, res_oob, cmd_oob, exc_valid;
   logic [3:0]    exc_code;
   logic [IW-1:0] exc_guard;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tguard_array #(
      .GUARD_CNT (GC), .IDX_W (IW), .SR_MAX_LEN (SRL),
      .CNT_W (CW), .DL_W (DW), .ARG_W (AW), .HAS_DEADLINE (1'b1)
   ) u_tguard_array (
      .clk (clk), .rst_n (rst_n), .host_mode (host_mode),
      .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_idx (cmd_idx),
      .cmd_arg (cmd_arg), .cmd_cond (cmd_cond),
      .q_valid (q_valid), .q_op (q_op), .q_idx_a (q_idx_a), .q_idx_b (q_idx_b),
      .res_valid (res_valid), .res_active (res_active), .res_oob (res_oob),
      .cmd_oob (cmd_oob), .exc_valid (exc_valid), .exc_code (exc_code),
      .exc_guard (exc_guard)
   );

   int  tests = 0;
   int  fails = 0;
   bit  done  = 1'b0;

   // bench model of each guard: kind 0 = shift, 1 = countdown
   int m_kind [GC];
   int m_len  [GC];
   int m_tgt  [GC];
   int m_run  [GC];
   int m_cond [GC];
   int m_arm  [GC];
   int m_dl   [GC];

   function automatic bit m_act(input int g);
      if (m_kind[g] == 1) return m_run[g] >= m_tgt[g];
      return m_run[g] >= m_len[g];
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int got, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic issue(input int op, input int idx, input int arg, input bit cond,
                        input bit wq, input int qa, input string req);
      bit exp_oob, exp_exc, exp_q, act;
      exp_q   = (wq && qa < GC) ? m_act(qa) : 1'b0;
      exp_oob = idx >= GC;
      exp_exc = 1'b0;
      if (!exp_oob) begin
         case (op)
            0: begin m_kind[idx] = 0; m_len[idx] = (arg % SRL) + 1; m_run[idx] = 0;
                     m_cond[idx] = cond; m_arm[idx] = 0; end
            1: begin m_kind[idx] = 1; m_tgt[idx] = arg % 16; m_run[idx] = 0;
                     m_cond[idx] = cond; m_arm[idx] = 0; end
            2: m_cond[idx] = cond;
            3: if (!host_mode) begin
                  if (m_cond[idx] != 0) begin
                     if (m_run[idx] < 1000) m_run[idx]++;
                  end else m_run[idx] = 0;
                  act = m_act(idx);
                  if (m_arm[idx] != 0) begin
                     if (act) m_arm[idx] = 0;
                     else if (m_dl[idx] == 1) begin exp_exc = 1'b1; m_arm[idx] = 0; end
                     else m_dl[idx]--;
                  end
               end
            4: begin m_dl[idx] = arg % 64; m_arm[idx] = (m_dl[idx] != 0); end
            default: ;
         endcase
      end
      cmd_valid = 1'b1; cmd_op = 3'(op); cmd_idx = IW'(idx); cmd_arg = AW'(arg);
      cmd_cond = cond; q_valid = wq; q_op = 2'd0; q_idx_a = IW'(qa);
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0; q_valid = 1'b0;
      chk(cmd_oob === exp_oob, req, "cmd_oob", int'(cmd_oob), int'(exp_oob));
      chk(exc_valid === exp_exc, req, "exc_valid", int'(exc_valid), int'(exp_exc));
      if (exp_exc) begin
         chk(exc_code === 4'd4, req, "exc_code", int'(exc_code), 4);
         chk(exc_guard === IW'(idx), req, "exc_guard", int'(exc_guard), idx);
      end
      if (wq) chk(res_active === exp_q, req, "same-edge query", int'(res_active), int'(exp_q));
   endtask

   task automatic cmd(input int op, input int idx, input int arg, input bit cond,
                      input string req);
      issue(op, idx, arg, cond, 1'b0, 0, req);
   endtask

   task automatic query(input int op, input int a, input int b, input string req);
      bit oob, va, vb, exp;
      oob = (a >= GC) || (((op == 1) || (op == 2)) && (b >= GC));
      va  = (a < GC) ? m_act(a) : 1'b0;
      vb  = (b < GC) ? m_act(b) : 1'b0;
      exp = oob ? 1'b0 : (op == 1) ? (va & vb) : (op == 2) ? (va | vb) : va;
      q_valid = 1'b1; q_op = 2'(op); q_idx_a = IW'(a); q_idx_b = IW'(b);
      @(posedge clk);
      @(negedge clk);
      q_valid = 1'b0;
      chk(res_valid === 1'b1, req, "res_valid", int'(res_valid), 1);
      chk(res_oob === oob, req, "res_oob", int'(res_oob), int'(oob));
      chk(res_active === exp, req, "res_active", int'(res_active), int'(exp));
   endtask

   task automatic all_guards(input string req);
      for (int g = 0; g < GC; g++) query(0, g, 0, req);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      for (int g = 0; g < GC; g++) begin
         m_kind[g] = 0; m_len[g] = 1; m_tgt[g] = 0; m_run[g] = 0;
         m_cond[g] = 0; m_arm[g] = 0; m_dl[g] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(res_valid === 1'b0, "R1", "res_valid", int'(res_valid), 0);
      chk(cmd_oob === 1'b0, "R1", "cmd_oob", int'(cmd_oob), 0);
      chk(exc_valid === 1'b0, "R1", "exc_valid", int'(exc_valid), 0);
      all_guards("R1");

      // R2 shift-history sweep over every length
      for (int len = 1; len <= SRL; len++) begin
         int g = len % GC;
         cmd(0, g, len - 1, 1'b1, "R2");
         for (int k = 0; k <= len; k++) begin
            query(0, g, 0, "R2");
            cmd(3, g, 0, 1'b0, "R2");
         end
         query(0, g, 0, "R2");
         cmd(2, g, 0, 1'b0, "R2");
         cmd(3, g, 0, 1'b0, "R2");
         query(0, g, 0, "R2");
         cmd(2, g, 0, 1'b1, "R2");
         cmd(3, g, 0, 1'b0, "R2");
         query(0, g, 0, "R2");
      end

      // R3 countdown sweep over every target
      for (int t = 0; t < 16; t++) begin
         cmd(1, 1, t, 1'b1, "R3");
         query(0, 1, 0, "R3");
         for (int k = 0; k <= t + 1; k++) begin
            cmd(3, 1, 0, 1'b0, "R3");
            query(0, 1, 0, "R3");
         end
         cmd(2, 1, 0, 1'b0, "R3");
         cmd(3, 1, 0, 1'b0, "R3");
         query(0, 1, 0, "R3");
         cmd(2, 1, 0, 1'b1, "R3");
         cmd(3, 1, 0, 1'b0, "R3");
         query(0, 1, 0, "R3");
      end

      // R4 condition latch
      cmd(0, 0, 0, 1'b0, "R4");
      cmd(3, 0, 0, 1'b0, "R4");
      query(0, 0, 0, "R4");
      cmd(2, 0, 0, 1'b1, "R4");
      query(0, 0, 0, "R4");
      cmd(3, 0, 0, 1'b0, "R4");
      query(0, 0, 0, "R4");

      // R5 combine sweep on mixed states
      cmd(0, 1, 1, 1'b0, "R5");
      cmd(0, 2, 0, 1'b1, "R5");
      cmd(3, 2, 0, 1'b0, "R5");
      cmd(0, 3, 0, 1'b0, "R5");
      cmd(1, 4, 0, 1'b1, "R5");
      cmd(1, 5, 3, 1'b1, "R5");
      for (int op = 0; op < 4; op++)
         for (int a = 0; a < GC; a++)
            for (int b = 0; b < GC; b++)
               query(op, a, b, "R5");
      // R5 query at the same edge as a tick sees the old state
      cmd(2, 3, 0, 1'b1, "R5");
      issue(3, 3, 0, 1'b0, 1'b1, 3, "R5");
      query(0, 3, 0, "R5");

      // R6 host mode suspends ticks and deadline progress
      host_mode = 1'b1;
      cmd(2, 2, 0, 1'b0, "R6");
      cmd(3, 2, 0, 1'b0, "R6");
      query(0, 2, 0, "R6");
      cmd(0, 3, 3, 1'b0, "R6");
      cmd(4, 3, 2, 1'b0, "R6");
      for (int k = 0; k < 3; k++) cmd(3, 3, 0, 1'b0, "R6");
      host_mode = 1'b0;
      cmd(3, 2, 0, 1'b0, "R6");
      query(0, 2, 0, "R6");
      cmd(3, 3, 0, 1'b0, "R6");
      cmd(3, 3, 0, 1'b0, "R6 R7");

      // R7 deadline miss on the D-th tick, single pulse
      cmd(0, 3, 3, 1'b0, "R7");
      cmd(4, 3, 3, 1'b0, "R7");
      for (int k = 0; k < 4; k++) cmd(3, 3, 0, 1'b0, "R7");
      cmd(4, 5, 63, 1'b0, "R7");
      cmd(2, 5, 0, 1'b0, "R7");
      for (int k = 0; k < 64; k++) cmd(3, 5, 0, 1'b0, "R7");

      // R8 firing disarms; fire on the last tick; zero disarms
      cmd(0, 3, 1, 1'b1, "R8");
      cmd(4, 3, 5, 1'b0, "R8");
      cmd(3, 3, 0, 1'b0, "R8");
      cmd(3, 3, 0, 1'b0, "R8");
      cmd(2, 3, 0, 1'b0, "R8");
      for (int k = 0; k < 6; k++) cmd(3, 3, 0, 1'b0, "R8");
      cmd(1, 5, 3, 1'b1, "R8");
      cmd(4, 5, 3, 1'b0, "R8");
      for (int k = 0; k < 3; k++) cmd(3, 5, 0, 1'b0, "R8");
      query(0, 5, 0, "R8");
      cmd(0, 4, 7, 1'b0, "R8");
      cmd(4, 4, 2, 1'b0, "R8");
      cmd(4, 4, 0, 1'b0, "R8");
      for (int k = 0; k < 4; k++) cmd(3, 4, 0, 1'b0, "R8");

      // R9 re-init clears deadline and history
      cmd(0, 4, 2, 1'b1, "R9");
      cmd(4, 4, 2, 1'b0, "R9");
      cmd(3, 4, 0, 1'b0, "R9");
      cmd(0, 4, 2, 1'b0, "R9");
      for (int k = 0; k < 3; k++) cmd(3, 4, 0, 1'b0, "R9");
      query(0, 4, 0, "R9");
      cmd(0, 0, 0, 1'b1, "R9");
      cmd(3, 0, 0, 1'b0, "R9");
      query(0, 0, 0, "R9");
      cmd(0, 0, 0, 1'b1, "R9");
      query(0, 0, 0, "R9");

      // R10 out-of-range indices
      cmd(3, 0, 0, 1'b1, "R10");
      cmd(3, 6, 0, 1'b0, "R10");
      cmd(0, 7, 0, 1'b0, "R10");
      cmd(2, 7, 0, 1'b0, "R10");
      cmd(1, 6, 5, 1'b0, "R10");
      all_guards("R10");
      query(0, 7, 0, "R10");
      query(1, 0, 6, "R10");
      query(2, 6, 0, "R10");
      query(0, 0, 7, "R10");

      // R11 unused opcodes have no effect
      cmd(0, 2, 0, 1'b1, "R11");
      cmd(3, 2, 0, 1'b0, "R11");
      for (int op = 5; op < 8; op++) begin
         cmd(op, 2, 0, 1'b0, "R11");
         cmd(op, 1, 255, 1'b1, "R11");
      end
      all_guards("R11");

      finish_run();
   end

endmodule